// File: doc/BRIEF.md
# Encoded-Request In-Order Grant Arbiter

The arbiter serves a group of clients that share one encoded request bus. On each clock the bus holds either zero, which means idle, or the index of one requesting client. The block answers with a single-cycle grant strobe. In the same cycle it drives the index of the served client on a destination field. Requests are served strictly in the order they were sampled, so the next grant after a request from client i goes to i unless an earlier request is still waiting.

Each sampled request first enters a one-entry capture stage. A request that cannot be granted at once moves into an ordered holding queue with one slot per client. A bypass path grants straight from the capture stage when nothing older is waiting. A parameterised spacing rule forces low cycles between two grants so that every grant is a distinct pulse. Because of this, bursts of back-to-back requests really do queue up. Each client is expected not to request again until its earlier grant has been seen.

Top module: `enc_grant_arbiter`

## Requirements
- R1: A synchronous active-high reset drives the grant low and the destination to 0 from the edge that samples it, and discards every request sampled before or during reset. None of them is granted afterwards.
- R2: A request value of 0 means no request and never causes a grant. The values 1 to 2**IDX_W-1 name clients 1 to 2**IDX_W-1 (1 to 7 by default).
- R3: The grant is high for exactly one cycle per served request. While it is high the destination holds the served client's index (never 0), and while it is low the destination is 0.
- R4: When nothing older is pending and the spacing rule allows it, the grant rises at the first clock edge after the edge that sampled the request.
- R5: Grants are issued in the order the requests were sampled. The next grant after a request from client i carries i whenever no earlier request is still waiting.
- R6: After a grant cycle the grant stays low for at least GAP_CYCLES cycles (default 1).
- R7: Requests from different clients on consecutive cycles are all held, and each one is granted exactly once.
- R8: Every request is granted within NUM_CLIENTS*(GAP_CYCLES+1) clock edges of its sampling edge.
- R9: No grant goes to a client without an outstanding request, and no request is granted twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_idx | input | IDX_W | Encoded requesting client, 0 = idle |
| ack | output | 1 | Single-cycle grant strobe |
| dest | output | IDX_W | Served client index while ack is high, else 0 |

## Verification
Isolated requests separated by idle time expose the bare one-edge latency of the bypass path, and long runs of zeros confirm that an idle bus never grants. A burst of all seven clients on consecutive cycles fills the queue behind the spacing rule, which separates true arrival-order service from any path that favours the newest request or drops entries. A reset in the middle of a burst shows whether held entries survive. Long pseudo-random traffic that respects the one-outstanding-per-client rule is compared every cycle against a behavioural arrival-list model, and each grant's wait is checked against the bound.

// File: rtl/encarb_pkg.sv
package encarb_pkg;

   // Default width of the encoded client index; clients are 1 .. 2**W-1.
   localparam int unsigned DEF_IDX_W = 3;

   // Default number of forced low cycles between two grant pulses.
   localparam int unsigned DEF_GAP_CYCLES = 1;

   // True when n is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

   // Counter width able to hold values 0 .. n.
   function automatic int unsigned span_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/encarb_capture.sv
module encarb_capture #(
   parameter int unsigned IDX_W = encarb_pkg::DEF_IDX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] req_idx,
   output logic             cap_vld,
   output logic [IDX_W-1:0] cap_idx
);

   logic             vld_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         idx_q <= '0;
      end else begin
         vld_q <= (req_idx != '0);
         idx_q <= req_idx;
      end
   end

   assign cap_vld = vld_q;
   assign cap_idx = idx_q;

   // R2
   idle_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (req_idx == '0) |=> !cap_vld);

endmodule

// File: rtl/encarb_order_q.sv
module encarb_order_q #(
   parameter int unsigned IDX_W = encarb_pkg::DEF_IDX_W,
   parameter int unsigned DEPTH = (1 << encarb_pkg::DEF_IDX_W) - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic [IDX_W-1:0] head_idx,
   output logic             empty,
   output logic             full
);

   localparam int unsigned PTR_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam int unsigned CNT_W = encarb_pkg::span_w(DEPTH);

   initial begin
      assert (DEPTH >= 1) else $error("order queue needs at least one slot");
   end

   logic [PTR_W-1:0]       wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]       fill_q;
   logic [DEPTH*IDX_W-1:0] slots_flat;

   // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
   generate
      if (encarb_pkg::is_pow2(DEPTH)) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   // One storage register per slot, each written only when it is the tail.
   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         logic [IDX_W-1:0] val_q;
         always_ff @(posedge clk) begin
            if (rst)
               val_q <= '0;
            else if (push && (wr_ptr == PTR_W'(s)))
               val_q <= push_idx;
         end
         assign slots_flat[s*IDX_W +: IDX_W] = val_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill_q <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

   assign head_idx = slots_flat[int'(rd_ptr)*IDX_W +: IDX_W];
   assign empty    = (fill_q == '0);
   assign full     = (fill_q == CNT_W'(DEPTH));

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (push && !pop) |-> !full);

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty);

   // R5
   head_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!pop && !empty && !$past(rst)) |=> $stable(head_idx));

endmodule

// File: rtl/encarb_pacer.sv
module encarb_pacer #(
   parameter int unsigned IDX_W      = encarb_pkg::DEF_IDX_W,
   parameter int unsigned GAP_CYCLES = encarb_pkg::DEF_GAP_CYCLES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             issue,
   input  logic [IDX_W-1:0] issue_idx,
   output logic             ready,
   output logic             ack,
   output logic [IDX_W-1:0] dest
);

   localparam int unsigned GAP_W = encarb_pkg::span_w(GAP_CYCLES);

   logic             ack_q;
   logic [IDX_W-1:0] dest_q;

   // Spacing variant: none, or a down-counter loaded on every grant.
   generate
      if (GAP_CYCLES == 0) begin : g_no_gap
         assign ready = 1'b1;
      end else begin : g_gap
         logic [GAP_W-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (rst)
               gap_q <= '0;
            else if (issue)
               gap_q <= GAP_W'(GAP_CYCLES);
            else if (gap_q != '0)
               gap_q <= gap_q - 1'b1;
         end
         assign ready = (gap_q == '0);

         // R6
         ack_spacing_chk: assert property (@(posedge clk) disable iff (rst)
            ack |=> !ack);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ack_q  <= 1'b0;
         dest_q <= '0;
      end else begin
         ack_q  <= issue;
         dest_q <= issue ? issue_idx : '0;
      end
   end

   assign ack  = ack_q;
   assign dest = dest_q;

   // R3
   dest_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !ack |-> (dest == '0));

   // R3
   dest_live_chk: assert property (@(posedge clk) disable iff (rst)
      ack |-> (dest != '0));

endmodule

// File: rtl/enc_grant_arbiter.sv
module enc_grant_arbiter #(
   parameter int unsigned IDX_W      = encarb_pkg::DEF_IDX_W,
   parameter int unsigned GAP_CYCLES = encarb_pkg::DEF_GAP_CYCLES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] req_idx,
   output logic             ack,
   output logic [IDX_W-1:0] dest
);

   localparam int unsigned NUM_CLIENTS = (1 << IDX_W) - 1;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 8) else $error("IDX_W out of range");
      assert (GAP_CYCLES <= 1024) else $error("GAP_CYCLES out of range");
   end

   logic             cap_vld;
   logic [IDX_W-1:0] cap_idx;
   logic             q_push, q_pop, q_empty, q_full;
   logic [IDX_W-1:0] q_head;
   logic             pace_ready;
   logic             issue;
   logic [IDX_W-1:0] issue_idx;

   encarb_capture #(.IDX_W(IDX_W)) u_capture (
      .clk     (clk),
      .rst     (rst),
      .req_idx (req_idx),
      .cap_vld (cap_vld),
      .cap_idx (cap_idx)
   );

   // Oldest waiting entry wins; the capture stage bypasses only an empty queue.
   always_comb begin
      q_pop     = pace_ready && !q_empty;
      issue     = pace_ready && (!q_empty || cap_vld);
      issue_idx = q_empty ? cap_idx : q_head;
      q_push    = cap_vld && !(pace_ready && q_empty);
   end

   encarb_order_q #(.IDX_W(IDX_W), .DEPTH(NUM_CLIENTS)) u_order_q (
      .clk      (clk),
      .rst      (rst),
      .push     (q_push),
      .push_idx (cap_idx),
      .pop      (q_pop),
      .head_idx (q_head),
      .empty    (q_empty),
      .full     (q_full)
   );

   encarb_pacer #(.IDX_W(IDX_W), .GAP_CYCLES(GAP_CYCLES)) u_pacer (
      .clk       (clk),
      .rst       (rst),
      .issue     (issue),
      .issue_idx (issue_idx),
      .ready     (pace_ready),
      .ack       (ack),
      .dest      (dest)
   );

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!ack && dest == '0));

   // R4
   bypass_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_vld && q_empty && pace_ready) |=> (ack && dest == $past(cap_idx)));

   // R5
   oldest_first_chk: assert property (@(posedge clk) disable iff (rst)
      (pace_ready && !q_empty) |=> (ack && dest == $past(q_head)));

   // R7
   queue_room_chk: assert property (@(posedge clk) disable iff (rst)
      (q_full && !pace_ready) |-> !cap_vld);

endmodule

// File: tb/enc_grant_arbiter_tb.sv
module enc_grant_arbiter_tb_top;

   localparam int IDX_W = 3;
   localparam int GAP   = 1;
   localparam int NCLI  = (1 << IDX_W) - 1;
   localparam int BOUND = NCLI * (GAP + 1);

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [IDX_W-1:0] req_drv = '0;
   logic             ack;
   logic [IDX_W-1:0] dest;

   always #5 clk = ~clk;

   enc_grant_arbiter #(.IDX_W(IDX_W), .GAP_CYCLES(GAP)) dut_i (
      .clk     (clk),
      .rst     (rst),
      .req_idx (req_drv),
      .ack     (ack),
      .dest    (dest)
   );

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Behavioural reference: list of sampled requests in arrival order.
   int edge_n = 0;
   int ref_pend[$];
   int ref_last = -1000;
   bit exp_ack = 1'b0;
   int exp_dest = 0;

   always @(posedge clk) begin
      edge_n++;
      if (rst) begin
         ref_pend.delete();
         ref_last = -1000;
         exp_ack  = 1'b0;
         exp_dest = 0;
      end else begin
         if (ref_pend.size() > 0 && (edge_n - ref_last) > GAP) begin
            exp_ack  = 1'b1;
            exp_dest = ref_pend.pop_front();
            ref_last = edge_n;
         end else begin
            exp_ack  = 1'b0;
            exp_dest = 0;
         end
         if (req_drv != '0) ref_pend.push_back(int'(req_drv));
      end
   end

   // Client bookkeeping kept by the bench.
   bit outstanding [1:NCLI];
   int sample_edge [1:NCLI];
   int ack_log[$];
   int dut_last = -1000;
   int ack_count = 0;

   always @(negedge clk) begin
      if (edge_n > 0) begin
         // R3 R5: per-cycle comparison against the reference
         check(ack === exp_ack, "R3 ack vs model", int'(ack), int'(exp_ack));
         check(int'(dest) == exp_dest, "R5 dest vs model", int'(dest), exp_dest);
      end
      if (rst) begin
         dut_last = -1000;
      end else if (ack === 1'b1) begin
         ack_count++;
         ack_log.push_back(int'(dest));
         if (dest != '0) begin
            // R9: grant only to an outstanding client
            check(outstanding[int'(dest)], "R9 grant to outstanding client", 0, 1);
            // R8: bounded wait
            check((edge_n - sample_edge[int'(dest)]) <= BOUND, "R8 grant latency",
                  edge_n - sample_edge[int'(dest)], BOUND);
            outstanding[int'(dest)] = 1'b0;
         end
         // R6: spacing between grants
         check((edge_n - dut_last) > GAP, "R6 grant spacing", edge_n - dut_last, GAP + 1);
         dut_last = edge_n;
      end
   end

   task automatic drive(input int c);
      @(posedge clk);
      #2;
      req_drv = IDX_W'(c);
      if (c != 0) begin
         outstanding[c] = 1'b1;
         sample_edge[c] = edge_n + 1;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0);
   endtask

   task automatic do_reset(input int n);
      @(posedge clk);
      #2;
      rst = 1'b1;
      req_drv = '0;
      for (int c = 1; c <= NCLI; c++) outstanding[c] = 1'b0;
      repeat (n) @(posedge clk);
      #2;
      rst = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      for (int c = 1; c <= NCLI; c++) begin
         outstanding[c] = 1'b0;
         sample_edge[c] = 0;
      end
      repeat (3) @(posedge clk);
      #2;
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(ack === 1'b0, "R1 reset ack", int'(ack), 0);
      check(dest == '0, "R1 reset dest", int'(dest), 0);

      // R2: idle bus never grants
      ack_count = 0;
      idle(12);
      @(negedge clk);
      check(ack_count == 0, "R2 idle bus grants", ack_count, 0);

      // R4: single request, grant at the edge after the sampling edge
      drive(3);
      drive(0);
      @(negedge clk);
      check(ack === 1'b0, "R4 not before next edge", int'(ack), 0);
      @(negedge clk);
      check(ack === 1'b1, "R4 bypass ack", int'(ack), 1);
      check(dest == 3'd3, "R4 bypass dest", int'(dest), 3);
      idle(6);

      // R5 R7: burst of every client on consecutive cycles
      ack_log.delete();
      for (int c = 1; c <= NCLI; c++) drive(c);
      idle(BOUND + 4);
      check(ack_log.size() == NCLI, "R7 burst grant count", ack_log.size(), NCLI);
      for (int k = 0; k < ack_log.size() && k < NCLI; k++)
         check(ack_log[k] == k + 1, "R5 burst order", ack_log[k], k + 1);

      // R5: reverse order burst
      ack_log.delete();
      for (int c = NCLI; c >= 1; c--) drive(c);
      idle(BOUND + 4);
      for (int k = 0; k < ack_log.size() && k < NCLI; k++)
         check(ack_log[k] == NCLI - k, "R5 reverse order", ack_log[k], NCLI - k);

      // R1: reset in the middle of a burst drops held requests
      for (int c = 1; c <= 4; c++) drive(c);
      do_reset(2);
      ack_log.delete();
      idle(BOUND + 4);
      check(ack_log.size() == 0, "R1 no grant after reset", ack_log.size(), 0);

      // Pseudo-random traffic, one outstanding request per client.
      for (int t = 0; t < 3000; t++) begin
         int pick;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pick = int'(lfsr[2:0]);
         if (lfsr[7:5] < 3'd4 && pick != 0 && !outstanding[pick]) drive(pick);
         else drive(0);
      end
      idle(BOUND + 6);

      // R8: everything served at the end
      begin
         int left = 0;
         for (int c = 1; c <= NCLI; c++) if (outstanding[c]) left++;
         check(left == 0, "R8 requests left unserved", left, 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule